// File: doc/BRIEF.md
# Dual 64-bit Alarm Timer Group

This block holds `NUM_TIMERS` identical timers (two by default, up to four) and one shared interrupt unit, all reached through a flat word-addressed register port. Each timer has a 64-bit counter driven by its own prescaler. The counter counts up or down, can be paused, and can be loaded by software at any moment. A 64-bit comparator raises an alarm event when the counter matches the programmed alarm value.

An alarm event disarms the comparator. If the timer is in reload mode, the event also puts the load value back into the counter. The interrupt unit keeps one raw status bit and one enable bit per timer, clears status through a write-one-to-clear mask, and drives one level interrupt line per timer.

The register port carries no stream traffic. A write is a single-cycle `reg_we` pulse with no back-pressure. Reads are combinational from `reg_raddr`. Timer `t` owns word addresses `8*t` to `8*t+7`. The group words sit at 32 to 35.

Top module: `tgrp_alarm_timers`

## Requirements
- R1: After reset, every counter, alarm value and load value reads 0. The group enable and raw status words read 0 and all `irq` lines are low. Each control word reads `INIT_DIV` in bits [31:16] (default 2, so 0x0002_0000) with bits [3:0] clear.
- R2: Control word (slot 0): bit0 run, bit1 up, bit2 reload, bit3 arm, bits [31:16] divider field. The counter steps once every D enabled cycles, where D is the field value for 2 to 65535 and 65536 when the field is 0.
- R3: A control write whose divider field is 1 leaves the divider unchanged, while bits [3:0] of the same write still take effect.
- R4: With bit1 set the counter increments, and with bit1 clear it decrements. Arithmetic is modulo 2^64, so a borrow crosses the 32-bit halves.
- R5: While bit0 is clear the counter holds its value, unless a load or a reload event occurs. Setting bit0 again resumes counting from the held value.
- R6: Slots 3 and 4 hold the low and high halves of the load value. Any write to slot 5 places the load value in the counter at that clock edge, whether or not the counter is running, and restarts the prescaler phase.
- R7: Any write to slot 6 copies the whole 64-bit counter into a snapshot register at that edge. Slots 6 and 7 read the snapshot's low and high halves, and slots 1 and 2 read the alarm value.
- R8: A cycle in which the arm bit is set and the counter equals the alarm value (slots 1 and 2) is an alarm event. The event sets raw status bit t at the next edge, whether or not the counter is running.
- R9: An alarm event clears the arm bit. No further event occurs for that timer until software sets the bit again. A control write in the same cycle as an event takes precedence.
- R10: If the reload bit is set, an alarm event loads the counter with the load value instead of stepping it. A software load in the same cycle takes precedence.
- R11: Word 32 holds the enable bits and word 33 the raw status bits, with bit t for timer t. Word 35 reads raw AND enable. `irq[t]` is high exactly while raw bit t and enable bit t are both set.
- R12: Writing a mask to word 34 clears the raw bits that are set in the mask. If an alarm event and a clear hit the same bit in the same cycle, the bit stays set.
- R13: Timers are independent. An event, write or count on timer t changes no state of another timer and no status bit other than bit t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe, one word per cycle |
| reg_waddr | input | 6 | Write word address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 6 | Read word address |
| reg_rdata | output | 32 | Combinational read data |
| irq | output | NUM_TIMERS | Level interrupt line per timer |

## Verification
The collision case is an alarm event and a write-one-to-clear of the same status bit landing on one clock edge. The bench pauses a counter on a value equal to its alarm. It arms the comparator with one write and issues the clear with the very next write, so the event and the clear meet at the same edge, and it then expects the raw bit to read back as set. A second collision, a software load during a cycle in which the prescaler would step, is judged by the exact counter value snapped afterwards.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int CNT_W     = 64;
  localparam int WORD_W    = 32;
  localparam int FIELD_W   = 16;
  localparam int DIV_W     = FIELD_W + 1;
  localparam int SLOT_W    = 3;
  localparam int GRP_SEL_W = 2;
  localparam int ADDR_W    = SLOT_W + GRP_SEL_W + 1;

  typedef enum logic [SLOT_W-1:0] {
    SL_CTRL      = 3'd0,
    SL_ALARM_LO  = 3'd1,
    SL_ALARM_HI  = 3'd2,
    SL_RELOAD_LO = 3'd3,
    SL_RELOAD_HI = 3'd4,
    SL_LOAD_GO   = 3'd5,
    SL_SNAP_LO   = 3'd6,
    SL_SNAP_HI   = 3'd7
  } slot_e;

  typedef enum logic [1:0] {
    GR_IRQ_EN   = 2'd0,
    GR_IRQ_RAW  = 2'd1,
    GR_IRQ_ACK  = 2'd2,
    GR_IRQ_PEND = 2'd3
  } grp_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             arm;
    logic             reload;
    logic             up;
    logic             run;
  } tmr_cfg_t;

  // a zero field encodes the largest divider
  function automatic logic [DIV_W-1:0] div_of_field(input logic [FIELD_W-1:0] f);
    if (f == '0) return {1'b1, {FIELD_W{1'b0}}};
    return {1'b0, f};
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_word(input tmr_cfg_t c);
    return {c.div[FIELD_W-1:0], 12'b0, c.arm, c.reload, c.up, c.run};
  endfunction
endpackage

// File: rtl/tg_prescaler.sv
module tg_prescaler
  import tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] ph_q;
  logic             at_end;

  // >= keeps the phase bounded if the divider shrinks mid-period
  assign at_end = (ph_q >= div - 1'b1);
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)       ph_q <= '0;
    else if (restart) ph_q <= '0;
    else if (run)     ph_q <= at_end ? '0 : ph_q + 1'b1;
  end
endmodule

// File: rtl/tg_count_core.sv
module tg_count_core
  import tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             up,
  input  logic             reload,
  input  logic             armed,
  input  logic             load_go,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] alarm_val,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;

  assign count = cnt_q;
  assign hit   = armed && (cnt_q == alarm_val);

  // software load beats reload, reload beats a prescaler step
  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_go)        cnt_q <= load_val;
    else if (hit && reload)  cnt_q <= load_val;
    else if (tick)           cnt_q <= up ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end
endmodule

// File: rtl/tg_irq_ctrl.sv
module tg_irq_ctrl #(
  parameter int NT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] evt,
  input  logic          en_we,
  input  logic [NT-1:0] en_wdata,
  input  logic [NT-1:0] ack_vec,
  output logic [NT-1:0] en_q,
  output logic [NT-1:0] raw_q,
  output logic [NT-1:0] line
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      raw_q <= '0;
    end else begin
      if (en_we) en_q <= en_wdata;
      // a new event outranks a clear of the same bit
      raw_q <= (raw_q & ~ack_vec) | evt;
    end
  end

  assign line = raw_q & en_q;
endmodule

// File: rtl/tgrp_alarm_timers.sv
module tgrp_alarm_timers
  import tg_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int INIT_DIV   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [5:0]            reg_waddr,
  input  logic [31:0]           reg_wdata,
  input  logic [5:0]            reg_raddr,
  output logic [31:0]           reg_rdata,
  output logic [NUM_TIMERS-1:0] irq
);
  localparam int NT = NUM_TIMERS;
  localparam logic [DIV_W-1:0] RST_DIV = DIV_W'(INIT_DIV);

  tmr_cfg_t         cfg_q    [NT];
  logic [CNT_W-1:0] alarm_q  [NT];
  logic [CNT_W-1:0] reload_q [NT];
  logic [CNT_W-1:0] snap_q   [NT];
  logic [CNT_W-1:0] count    [NT];
  logic [WORD_W-1:0] tmr_rd  [NT];

  logic [NT-1:0] wr_hit, ctl_wr, ld_go, tick, hit;
  logic [NT-1:0] arm_v, run_v, rld_v;
  logic [NT-1:0] irq_en, irq_raw, ack_vec;

  logic                 wr_grp, rd_grp;
  logic [GRP_SEL_W-1:0] wr_tsel, rd_tsel;
  slot_e                wr_slot, rd_slot;
  logic                 en_we;

  assign wr_grp  = reg_waddr[ADDR_W-1];
  assign wr_tsel = reg_waddr[SLOT_W +: GRP_SEL_W];
  assign wr_slot = slot_e'(reg_waddr[SLOT_W-1:0]);
  assign rd_grp  = reg_raddr[ADDR_W-1];
  assign rd_tsel = reg_raddr[SLOT_W +: GRP_SEL_W];
  assign rd_slot = slot_e'(reg_raddr[SLOT_W-1:0]);

  assign en_we   = reg_we && wr_grp && (grp_e'(reg_waddr[1:0]) == GR_IRQ_EN);
  assign ack_vec = (reg_we && wr_grp && (grp_e'(reg_waddr[1:0]) == GR_IRQ_ACK))
                   ? reg_wdata[NT-1:0] : '0;

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    assign wr_hit[t] = reg_we && !wr_grp && (wr_tsel == GRP_SEL_W'(t));
    assign ctl_wr[t] = wr_hit[t] && (wr_slot == SL_CTRL);
    assign ld_go[t]  = wr_hit[t] && (wr_slot == SL_LOAD_GO);
    assign arm_v[t]  = cfg_q[t].arm;
    assign run_v[t]  = cfg_q[t].run;
    assign rld_v[t]  = cfg_q[t].reload;

    tg_prescaler u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (cfg_q[t].run),
      .restart (ld_go[t]),
      .div     (cfg_q[t].div),
      .tick    (tick[t])
    );

    tg_count_core u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick[t]),
      .up        (cfg_q[t].up),
      .reload    (cfg_q[t].reload),
      .armed     (cfg_q[t].arm),
      .load_go   (ld_go[t]),
      .load_val  (reload_q[t]),
      .alarm_val (alarm_q[t]),
      .count     (count[t]),
      .hit       (hit[t])
    );

    always_comb begin
      case (rd_slot)
        SL_CTRL:      tmr_rd[t] = ctrl_word(cfg_q[t]);
        SL_ALARM_LO:  tmr_rd[t] = alarm_q[t][WORD_W-1:0];
        SL_ALARM_HI:  tmr_rd[t] = alarm_q[t][CNT_W-1:WORD_W];
        SL_RELOAD_LO: tmr_rd[t] = reload_q[t][WORD_W-1:0];
        SL_RELOAD_HI: tmr_rd[t] = reload_q[t][CNT_W-1:WORD_W];
        SL_SNAP_LO:   tmr_rd[t] = snap_q[t][WORD_W-1:0];
        SL_SNAP_HI:   tmr_rd[t] = snap_q[t][CNT_W-1:WORD_W];
        default:      tmr_rd[t] = '0;
      endcase
    end
  end

  // per-timer register file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) begin
        cfg_q[t]    <= '{div: RST_DIV, arm: 1'b0, reload: 1'b0, up: 1'b0, run: 1'b0};
        alarm_q[t]  <= '0;
        reload_q[t] <= '0;
        snap_q[t]   <= '0;
      end
    end else begin
      for (int t = 0; t < NT; t++) begin
        if (ctl_wr[t]) begin
          cfg_q[t].run    <= reg_wdata[0];
          cfg_q[t].up     <= reg_wdata[1];
          cfg_q[t].reload <= reg_wdata[2];
          cfg_q[t].arm    <= reg_wdata[3];
          if (reg_wdata[WORD_W-1 -: FIELD_W] != FIELD_W'(1))
            cfg_q[t].div <= div_of_field(reg_wdata[WORD_W-1 -: FIELD_W]);
        end else if (hit[t]) begin
          cfg_q[t].arm <= 1'b0;
        end
        if (wr_hit[t]) begin
          case (wr_slot)
            SL_ALARM_LO:  alarm_q[t][WORD_W-1:0]      <= reg_wdata;
            SL_ALARM_HI:  alarm_q[t][CNT_W-1:WORD_W]  <= reg_wdata;
            SL_RELOAD_LO: reload_q[t][WORD_W-1:0]     <= reg_wdata;
            SL_RELOAD_HI: reload_q[t][CNT_W-1:WORD_W] <= reg_wdata;
            SL_SNAP_LO:   snap_q[t]                   <= count[t];
            default:      ;
          endcase
        end
      end
    end
  end

  tg_irq_ctrl #(.NT(NT)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (hit),
    .en_we    (en_we),
    .en_wdata (reg_wdata[NT-1:0]),
    .ack_vec  (ack_vec),
    .en_q     (irq_en),
    .raw_q    (irq_raw),
    .line     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (rd_grp) begin
      case (grp_e'(reg_raddr[1:0]))
        GR_IRQ_EN:   reg_rdata[NT-1:0] = irq_en;
        GR_IRQ_RAW:  reg_rdata[NT-1:0] = irq_raw;
        GR_IRQ_PEND: reg_rdata[NT-1:0] = irq;
        default:     reg_rdata = '0;
      endcase
    end else begin
      for (int t = 0; t < NT; t++)
        if (rd_tsel == GRP_SEL_W'(t)) reg_rdata = tmr_rd[t];
    end
  end
endmodule

// File: rtl/tgrp_alarm_timers_chk.sv
module tgrp_alarm_timers_chk #(
  parameter int NT = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [63:0]   count    [NT],
  input logic [63:0]   reload_q [NT],
  input logic [NT-1:0] hit,
  input logic [NT-1:0] arm_v,
  input logic [NT-1:0] run_v,
  input logic [NT-1:0] rld_v,
  input logic [NT-1:0] ld_go,
  input logic [NT-1:0] ctl_wr,
  input logic [NT-1:0] raw,
  input logic [NT-1:0] en,
  input logic [NT-1:0] irq,
  input logic [NT-1:0] ack_vec
);
  for (genvar t = 0; t < NT; t++) begin : g_chk
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ld_go[t] |=> count[t] == $past(reload_q[t])); // R6
    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_v[t] && !ld_go[t] && !(hit[t] && rld_v[t])) |=> count[t] == $past(count[t])); // R5
    AST_RAW_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      hit[t] |=> raw[t]); // R8
    AST_SELF_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[t] && !ctl_wr[t]) |=> !arm_v[t]); // R9
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[t] && rld_v[t] && !ld_go[t]) |=> count[t] == $past(reload_q[t])); // R10
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !en[t] |-> !irq[t]); // R11
    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[t] && !ack_vec[t]) |=> raw[t]); // R12
  end
endmodule

bind tgrp_alarm_timers tgrp_alarm_timers_chk #(.NT(NUM_TIMERS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .count    (count),
  .reload_q (reload_q),
  .hit      (hit),
  .arm_v    (arm_v),
  .run_v    (run_v),
  .rld_v    (rld_v),
  .ld_go    (ld_go),
  .ctl_wr   (ctl_wr),
  .raw      (irq_raw),
  .en       (irq_en),
  .irq      (irq),
  .ack_vec  (ack_vec)
);

// File: tb/tgrp_alarm_timers_bench.sv
module tgrp_alarm_timers_bench;
  localparam int CTRL = 0, ALO = 1, AHI = 2, LLO = 3, LHI = 4, LGO = 5, SNL = 6, SNH = 7;
  localparam int IEN = 32, IRAW = 33, IACK = 34, IPEND = 35;

  typedef struct {
    bit          pins;
    logic [5:0]  addr;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [5:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  irq;

  sb_item_t sb_q[$];
  int pending = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tgrp_alarm_timers u_tgrp_alarm_timers (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  // monitor: pops one expected item per falling edge and compares
  always @(negedge clk) begin : mon
    sb_item_t it;
    logic [31:0] act;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      reg_raddr = it.addr;
      #2;
      act = it.pins ? {30'b0, irq} : reg_rdata;
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
      pending--;
    end
  end

  function automatic logic [31:0] cw(bit run, bit up, bit rld, bit arm, logic [15:0] f);
    return {f, 12'b0, arm, rld, up, run};
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_waddr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input bit pins, input int a, input logic [31:0] e, input string tag);
    sb_item_t it;
    it.pins = pins; it.addr = 6'(a); it.exp = e; it.tag = tag;
    pending++;
    sb_q.push_back(it);
    wait (pending == 0);
    @(negedge clk);
  endtask

  task automatic expect_rd(input int a, input logic [31:0] e, input string tag);
    push(1'b0, a, e, tag);
  endtask

  task automatic expect_irq(input logic [31:0] e, input string tag);
    push(1'b1, 0, e, tag);
  endtask

  task automatic expect_cnt(input int t, input logic [63:0] e, input string tag);
    wr(t*8 + SNL, 32'h0);
    expect_rd(t*8 + SNL, e[31:0], tag);
    expect_rd(t*8 + SNH, e[63:32], tag);
  endtask

  task automatic load(input int t, input logic [63:0] v);
    wr(t*8 + LLO, v[31:0]);
    wr(t*8 + LHI, v[63:32]);
    wr(t*8 + LGO, 32'h0);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_cnt(0, 64'h0, "R1 counter after reset");
    expect_rd(CTRL, 32'h0002_0000, "R1 control default");
    expect_rd(IEN, 32'h0, "R1 enable word");
    expect_rd(IRAW, 32'h0, "R1 raw word");
    expect_irq(32'h0, "R1 irq lines");

    // R6 R7 load while stopped, coherent snapshot
    load(0, 64'h1_0000_0010);
    expect_cnt(0, 64'h1_0000_0010, "R6 R7 load while stopped");

    // R2 R4 up count, divider 2: 10 enabled edges give 5 steps
    wr(CTRL, cw(1, 1, 0, 0, 16'd2));
    idle(9);
    wr(CTRL, cw(0, 1, 0, 0, 16'd2));
    expect_cnt(0, 64'h1_0000_0015, "R2 R4 up count");
    idle(6);
    expect_cnt(0, 64'h1_0000_0015, "R5 paused counter holds");

    // R4 R5 down count resumes from held value
    wr(CTRL, cw(1, 0, 0, 0, 16'd2));
    idle(9);
    wr(CTRL, cw(0, 0, 0, 0, 16'd2));
    expect_cnt(0, 64'h1_0000_0010, "R4 R5 down count");

    // R4 borrow across halves
    load(0, 64'h1_0000_0000);
    wr(CTRL, cw(1, 0, 0, 0, 16'd2));
    idle(1);
    wr(CTRL, cw(0, 0, 0, 0, 16'd2));
    expect_cnt(0, 64'h0_FFFF_FFFF, "R4 borrow");

    // R2 divider 3: 9 enabled edges give 3 steps
    load(0, 64'h0);
    wr(CTRL, cw(1, 1, 0, 0, 16'd3));
    idle(8);
    wr(CTRL, cw(0, 1, 0, 0, 16'd3));
    expect_cnt(0, 64'd3, "R2 divider 3");

    // R3 divider field 1 rejected
    wr(CTRL, cw(0, 1, 0, 0, 16'd1));
    expect_rd(CTRL, cw(0, 1, 0, 0, 16'd3), "R3 field 1 keeps divider");
    load(0, 64'h0);
    wr(CTRL, cw(1, 1, 0, 0, 16'd1));
    idle(8);
    wr(CTRL, cw(0, 1, 0, 0, 16'd1));
    expect_cnt(0, 64'd3, "R3 still divides by 3");

    // R2 field 0 means 65536
    wr(CTRL, cw(0, 1, 0, 0, 16'd0));
    expect_rd(CTRL, cw(0, 1, 0, 0, 16'd0), "R2 field 0 accepted");
    load(0, 64'h0);
    wr(CTRL, cw(1, 1, 0, 0, 16'd0));
    idle(8);
    wr(CTRL, cw(0, 1, 0, 0, 16'd0));
    expect_cnt(0, 64'd0, "R2 divide by 65536 no step");

    // R6 load while running restarts prescaler phase
    wr(LLO, 32'h50);
    wr(LHI, 32'h0);
    wr(CTRL, cw(1, 1, 0, 0, 16'd2));
    wr(LGO, 32'h0);
    idle(3);
    wr(CTRL, cw(0, 1, 0, 0, 16'd2));
    expect_cnt(0, 64'h52, "R6 load while running");

    // R8 R9 R11 alarm without reload
    load(0, 64'h0);
    wr(ALO, 32'd3);
    wr(AHI, 32'h0);
    wr(IEN, 32'h1);
    wr(CTRL, cw(1, 1, 0, 1, 16'd2));
    idle(20);
    expect_rd(CTRL, cw(1, 1, 0, 0, 16'd2), "R9 arm cleared by event");
    wr(CTRL, cw(0, 1, 0, 0, 16'd2));
    expect_rd(IRAW, 32'h1, "R8 raw set");
    expect_rd(IPEND, 32'h1, "R11 pending word");
    idle(5);
    expect_irq(32'h1, "R11 level held");
    wr(IACK, 32'h1);
    expect_rd(IRAW, 32'h0, "R12 clear");
    expect_irq(32'h0, "R12 irq drops");

    // R9 no event while unarmed even when passing the alarm value
    load(0, 64'h0);
    wr(CTRL, cw(1, 1, 0, 0, 16'd2));
    idle(20);
    wr(CTRL, cw(0, 1, 0, 0, 16'd2));
    expect_rd(IRAW, 32'h0, "R9 no event while unarmed");

    // R10 reload on event
    load(0, 64'h100);
    wr(ALO, 32'h102);
    wr(CTRL, cw(1, 1, 1, 1, 16'd2));
    idle(5);
    wr(CTRL, cw(0, 1, 1, 0, 16'd2));
    expect_cnt(0, 64'h101, "R10 counter reloaded");
    expect_rd(IRAW, 32'h1, "R10 event raised");
    wr(IACK, 32'h1);

    // R12 event and clear on the same edge: set wins
    wr(ALO, 32'h101);
    wr(CTRL, cw(0, 1, 0, 1, 16'd2));
    wr(IACK, 32'h1);
    expect_rd(IRAW, 32'h1, "R12 set wins over clear");
    expect_rd(CTRL, cw(0, 1, 0, 0, 16'd2), "R9 disarm when paused");
    wr(IACK, 32'h1);
    expect_rd(IRAW, 32'h0, "R12 later clear");

    // R13 second timer independent, R11 masking
    wr(8 + CTRL, cw(0, 1, 0, 1, 16'd2));
    expect_rd(IRAW, 32'h2, "R13 only bit 1 set");
    expect_rd(IPEND, 32'h0, "R11 masked pending");
    expect_irq(32'h0, "R11 masked line low");
    wr(IEN, 32'h3);
    expect_irq(32'h2, "R13 line 1 only");
    expect_cnt(0, 64'h101, "R13 timer 0 untouched");
    wr(IACK, 32'h2);
    expect_irq(32'h0, "R12 clear bit 1");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule